// File: doc/BRIEF.md
# Return Address Stack with Interrupt Guard

This block keeps the return addresses of a small processor core. When a subroutine call is executed, or when an interrupt is taken, the core presents its current program counter and the block saves it on the stack. A return of either kind (a plain return or a return from an interrupt) pops the newest saved address and hands it back to the core. The stack has six levels by default. The storage and its pointer have no path to software.

An interrupt guard sits between the interrupt controller and the stack. While every level is in use, a pending interrupt is held off: the acknowledge-allowed output stays low, and the request remains pending at the controller. The first return that frees a level lets the interrupt through. A subroutine call is treated differently. A call on a full stack still saves its address, and the oldest saved address is dropped.

Occupancy is tracked by a three-state machine:
- `OCC_EMPTY` (no entries) goes to `OCC_PARTIAL` on a push.
- `OCC_PARTIAL` goes to `OCC_EMPTY` when the last entry is popped.
- `OCC_PARTIAL` goes to `OCC_FULL` when the last free level is filled.
- `OCC_FULL` goes back to `OCC_PARTIAL` on a pop that has no push in the same cycle.
- `OCC_FULL` stays in place on an overwriting call and on a combined push and pop.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `ret_pc` is 0 and `irq_ack_ok` is 0.
- R2: `call_push` saves `cur_pc` at the clock edge. `ret_pc` always shows the newest saved entry. Each `ret_pop` removes that entry at the edge, so addresses come back in last-in, first-out order.
- R3: `irq_enter` saves `cur_pc` exactly as a call does, as long as the stack is not full. The saved entry is returned by the same `ret_pop` input.
- R4: With the default depth of 6, six pushes from empty set `full` to 1 and `empty` to 0. The two flags are never 1 together.
- R5: `irq_ack_ok` is combinationally equal to `irq_pending` AND NOT `full`.
- R6: `irq_enter` while `full` is 1 has no effect on the stack contents or on the occupancy.
- R7: When `irq_pending` stays high on a full stack, `irq_ack_ok` becomes 1 in the cycle after a `ret_pop` edge.
- R8: `call_push` on a full stack still saves `cur_pc` and discards the oldest entry. `full` stays 1. Seven calls followed by pops return the last six values, newest first.
- R9: `ret_pop` on an empty stack shows `ret_pc` = 0 and leaves the stack empty. A push after that works normally.
- R10: A push and a pop in the same cycle act as the pop followed by the push. During that cycle `ret_pc` shows the old top, and after the edge the new address replaces it with the count unchanged. On an empty stack the same pair leaves exactly one entry, the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_push | input | 1 | Subroutine call: save `cur_pc` |
| irq_enter | input | 1 | Interrupt entry: save `cur_pc` unless full |
| ret_pop | input | 1 | Return or return from interrupt: remove top entry |
| cur_pc | input | PC_W | Program counter to save |
| irq_pending | input | 1 | Unmasked interrupt request is pending |
| irq_ack_ok | output | 1 | Interrupt entry is allowed now |
| ret_pc | output | PC_W | Newest saved address, 0 when empty |
| full | output | 1 | All levels hold an address |
| empty | output | 1 | No level holds an address |

## Verification
Some properties hold in every cycle, and the assertions check these continuously:
- the interrupt gate's relation to `full` and `irq_pending`;
- the zero readout on an empty stack;
- the two flags never being set together;
- an empty pop leaving the stack empty;
- an overwriting call or a combined push and pop keeping a full stack full;
- an interrupt entry on a full stack leaving the top entry unchanged.

Other behaviour depends on whole sequences of pushes and pops, and only the directed scenarios can show it:
- last-in, first-out ordering;
- which entry is lost on overwrite;
- the order of a combined push and pop;
- the gate reopening one cycle after a return.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

endpackage

// File: rtl/ras_ring.sv
module ras_ring #(
    parameter int DEPTH = 6,
    parameter int PC_W  = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            do_push,
    input  logic            do_pop,
    input  logic            has_data,
    input  logic [PC_W-1:0] wr_pc,
    output logic [PC_W-1:0] top_pc
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PC_W-1:0]  slot_q [DEPTH];
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] peek_idx;
    logic [PTR_W-1:0] base_idx;
    logic [PTR_W-1:0] base_inc;

    // Index of the newest entry: one below the write head, wrapping round.
    always_comb begin
        peek_idx = (head_q == '0) ? LAST : head_q - PTR_W'(1);
        // A pop is applied first, then the push writes at the resulting head.
        base_idx = (do_pop && has_data) ? peek_idx : head_q;
        base_inc = (base_idx == LAST) ? '0 : base_idx + PTR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
        end else if (do_push) begin
            head_q <= base_inc;
        end else begin
            head_q <= base_idx;
        end
    end

    // On a full ring the head points at the oldest entry, so a push overwrites it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (do_push && base_idx == PTR_W'(g)) begin
                slot_q[g] <= wr_pc;
            end
        end
    end

    assign top_pc = has_data ? slot_q[peek_idx] : '0;

endmodule

// File: rtl/ras_occupancy.sv
module ras_occupancy
    import ras_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_push,
    input  logic do_pop,
    output logic is_full,
    output logic is_empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    occ_state_t       state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx, cnt_mid;
    logic             popped;

    always_comb begin
        popped  = do_pop && (state_q != OCC_EMPTY);
        cnt_mid = cnt_q - CNT_W'(popped);
        cnt_nx  = (do_push && cnt_mid != CAP) ? cnt_mid + CNT_W'(1) : cnt_mid;
        state_nx = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (do_push) begin
                    state_nx = (cnt_nx == CAP) ? OCC_FULL : OCC_PARTIAL;
                end
            end
            OCC_PARTIAL: begin
                if (cnt_nx == '0) begin
                    state_nx = OCC_EMPTY;
                end else if (cnt_nx == CAP) begin
                    state_nx = OCC_FULL;
                end
            end
            OCC_FULL: begin
                if (popped && !do_push) begin
                    state_nx = (cnt_nx == '0) ? OCC_EMPTY : OCC_PARTIAL;
                end
            end
            default: state_nx = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    always_comb begin
        is_full  = 1'b0;
        is_empty = 1'b0;
        unique case (state_q)
            OCC_EMPTY:   is_empty = 1'b1;
            OCC_PARTIAL: ;
            OCC_FULL:    is_full  = 1'b1;
            default:     is_empty = 1'b1;
        endcase
    end

endmodule

// File: rtl/ras_guard.sv
module ras_guard (
    input  logic call_req,
    input  logic irq_req,
    input  logic irq_pend,
    input  logic is_full,
    output logic push_go,
    output logic ack_ok
);
    // Interrupt entry is refused while every level is occupied; calls always push.
    assign ack_ok  = irq_pend && !is_full;
    assign push_go = call_req || (irq_req && !is_full);
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
    parameter int DEPTH = 6,
    parameter int PC_W  = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_push,
    input  logic            irq_enter,
    input  logic            ret_pop,
    input  logic [PC_W-1:0] cur_pc,
    input  logic            irq_pending,
    output logic            irq_ack_ok,
    output logic [PC_W-1:0] ret_pc,
    output logic            full,
    output logic            empty
);
    logic push_go;

    ras_guard u_guard (
        .call_req (call_push),
        .irq_req  (irq_enter),
        .irq_pend (irq_pending),
        .is_full  (full),
        .push_go  (push_go),
        .ack_ok   (irq_ack_ok)
    );

    ras_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_push  (push_go),
        .do_pop   (ret_pop),
        .is_full  (full),
        .is_empty (empty)
    );

    ras_ring #(.DEPTH(DEPTH), .PC_W(PC_W)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_push  (push_go),
        .do_pop   (ret_pop),
        .has_data (!empty),
        .wr_pc    (cur_pc),
        .top_pc   (ret_pc)
    );

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
    parameter int PC_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            call_push,
    input logic            irq_enter,
    input logic            ret_pop,
    input logic            irq_pending,
    input logic            irq_ack_ok,
    input logic [PC_W-1:0] ret_pc,
    input logic            full,
    input logic            empty
);
    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_ack_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !irq_ack_ok);

    assert_ack_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && irq_pending) |-> irq_ack_ok);

    assert_irq_full_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && irq_enter && !call_push && !ret_pop) |=> (full && $stable(ret_pc)));

    assert_call_full_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && call_push && !ret_pop) |=> full);

    assert_empty_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (ret_pc == '0));

    assert_empty_pop_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && ret_pop && !call_push && !irq_enter) |=> empty);

    assert_push_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (call_push && !ret_pop) |=> !empty);

    assert_pair_keeps_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && ret_pop && call_push) |=> full);

endmodule

bind ret_addr_stack ras_checker #(.PC_W(PC_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .call_push   (call_push),
    .irq_enter   (irq_enter),
    .ret_pop     (ret_pop),
    .irq_pending (irq_pending),
    .irq_ack_ok  (irq_ack_ok),
    .ret_pc      (ret_pc),
    .full        (full),
    .empty       (empty)
);

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;
    localparam int PC_W = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            call_push = 1'b0;
    logic            irq_enter = 1'b0;
    logic            ret_pop = 1'b0;
    logic [PC_W-1:0] cur_pc = '0;
    logic            irq_pending = 1'b0;
    logic            irq_ack_ok;
    logic [PC_W-1:0] ret_pc;
    logic            full;
    logic            empty;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ret_addr_stack #(.DEPTH(6), .PC_W(PC_W)) i_ret_addr_stack (
        .clk(clk), .rst_n(rst_n), .call_push(call_push), .irq_enter(irq_enter),
        .ret_pop(ret_pop), .cur_pc(cur_pc), .irq_pending(irq_pending),
        .irq_ack_ok(irq_ack_ok), .ret_pc(ret_pc), .full(full), .empty(empty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs at the falling edge; outputs settle 1 ns later.
    task automatic drive(input logic c, input logic i, input logic p, input logic [PC_W-1:0] pc);
        @(negedge clk);
        call_push = c; irq_enter = i; ret_pop = p; cur_pc = pc;
        #1;
    endtask

    task automatic idle();
        drive(0, 0, 0, '0);
    endtask

    task automatic t_reset();
        idle();
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 ret_pc", ret_pc, 0);
        irq_pending = 1'b0; #0.1;
        check("R1 ack", irq_ack_ok, 0);
    endtask

    task automatic t_lifo();
        drive(1, 0, 0, 12'h111);
        drive(1, 0, 0, 12'h222);
        drive(1, 0, 0, 12'h333);
        drive(0, 0, 1, '0); check("R2 pop1", ret_pc, 12'h333);
        drive(0, 0, 1, '0); check("R2 pop2", ret_pc, 12'h222);
        drive(0, 0, 1, '0); check("R2 pop3", ret_pc, 12'h111);
        idle(); check("R2 empty after", empty, 1);
    endtask

    task automatic t_irq_push();
        irq_pending = 1'b1;
        idle(); check("R5 ack open", irq_ack_ok, 1);
        drive(0, 1, 0, 12'hABC);
        irq_pending = 1'b0;
        idle(); check("R5 ack low w/o pending", irq_ack_ok, 0);
        drive(0, 0, 1, '0); check("R3 irq entry popped", ret_pc, 12'hABC);
        idle(); check("R3 empty after", empty, 1);
    endtask

    task automatic t_full_guard();
        for (int k = 1; k <= 6; k++) drive(1, 0, 0, PC_W'(12'h100 + k));
        irq_pending = 1'b1;
        idle();
        check("R4 full", full, 1);
        check("R4 not empty", empty, 0);
        check("R5 ack blocked", irq_ack_ok, 0);
        drive(0, 1, 0, 12'hFFF);
        idle();
        check("R6 still full", full, 1);
        check("R6 top unchanged", ret_pc, 12'h106);
        drive(0, 0, 1, '0);
        check("R6 pop after ignored irq", ret_pc, 12'h106);
        check("R7 ack still low in pop cycle", irq_ack_ok, 0);
        idle();
        check("R7 ack after pop", irq_ack_ok, 1);
        check("R7 full cleared", full, 0);
        irq_pending = 1'b0;
        for (int k = 5; k >= 1; k--) begin
            drive(0, 0, 1, '0);
            check("R6 drain", ret_pc, PC_W'(12'h100 + k));
        end
        idle(); check("R6 empty", empty, 1);
    endtask

    task automatic t_overwrite();
        for (int k = 1; k <= 7; k++) drive(1, 0, 0, PC_W'(k));
        idle(); check("R8 full after 7", full, 1);
        for (int k = 7; k >= 2; k--) begin
            drive(0, 0, 1, '0);
            check("R8 pop order", ret_pc, PC_W'(k));
        end
        idle();
        check("R8 oldest lost empty", empty, 1);
        check("R8 oldest lost data", ret_pc, 0);
    endtask

    task automatic t_empty_pop();
        drive(0, 0, 1, '0); check("R9 empty pop data", ret_pc, 0);
        idle(); check("R9 still empty", empty, 1);
        drive(1, 0, 0, 12'h055);
        idle(); check("R9 push after", ret_pc, 12'h055);
        drive(0, 0, 1, '0);
        idle(); check("R9 empty again", empty, 1);
    endtask

    task automatic t_same_cycle();
        drive(1, 0, 0, 12'h0A0);
        drive(1, 0, 0, 12'h0B0);
        drive(1, 0, 1, 12'h0C0); check("R10 old top shown", ret_pc, 12'h0B0);
        idle(); check("R10 replaced", ret_pc, 12'h0C0);
        drive(0, 0, 1, '0); check("R10 new top", ret_pc, 12'h0C0);
        drive(0, 0, 1, '0); check("R10 below kept", ret_pc, 12'h0A0);
        idle(); check("R10 drained", empty, 1);
        drive(1, 0, 1, 12'h0D0); check("R10 empty pair data", ret_pc, 0);
        idle(); check("R10 empty pair count", empty, 0);
        drive(0, 0, 1, '0); check("R10 empty pair value", ret_pc, 12'h0D0);
        idle(); check("R10 single entry", empty, 1);
    endtask

    initial begin
        #12 rst_n = 1'b1;
        t_reset();
        t_lifo();
        t_irq_push();
        t_full_guard();
        t_overwrite();
        t_empty_pop();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule